// File: doc/BRIEF.md
# Envelope-Gated Carrier Tone Generator

This block turns a slow logic-level envelope into a gated 22 kHz square-wave drive bit. A downstream power stage uses that bit to superimpose a carrier on a supply rail. While the envelope is high the block emits a 50 % duty square wave. The frequency comes from dividing the system clock, and every divider constant is derived from the clock-frequency parameter.

The carrier does not follow the envelope directly. Starting is deliberately late: the envelope must stay high for a fixed delay of about 6 µs before the first high phase appears, so short glitches produce nothing. Stopping is also deliberate. After the envelope falls, a countdown measured in whole half periods keeps the carrier going for roughly 35 µs. The carrier ends only at a half-period boundary, so no high phase is ever shortened. If the envelope returns during that countdown, the stop is cancelled and the carrier carries on in its existing phase.

A global output-enable from the control register masks the output at once and sends the sequencer back to idle. The envelope input is asynchronous and passes through a two-flop synchronizer.

Top module: `tone_env_gen`

## Requirements
- R1: The carrier period (one high plus one low phase) lies between 20 kHz and 24 kHz of the clock, i.e. 2084 to 2500 cycles at 50 MHz.
- R2: While running, each high phase and each low phase last the same number of clock cycles, giving a duty cycle within 43 % to 57 %.
- R3: After the envelope rises from idle, the first high phase begins between 5 µs and 7 µs later (250 to 350 cycles at 50 MHz).
- R4: An envelope pulse that falls before the start delay has elapsed produces no high output at all.
- R5: After the envelope falls, the final falling edge of the output occurs within 60 µs, and the output then stays low. The carrier also stays active for at least 15 µs: the final falling edge plus one half period lies at least 15 µs after the fall.
- R6: The last high phase before the carrier stops has the full half-period length.
- R7: If the envelope rises again before the carrier has stopped, the carrier continues without a phase restart, so every phase keeps the regular half-period length.
- R8: While the output-enable is low the output is low, in the same cycle the enable drops, regardless of the envelope.
- R9: While reset is active the output is low, and after reset with the envelope low the output stays low.
- R10: When the output-enable returns while the envelope is high, the carrier restarts after the same 5 µs to 7 µs start delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| env_i | input | 1 | Asynchronous envelope; high requests the carrier |
| en_i | input | 1 | Global output-enable; low forces the output low and idles the sequencer |
| tone_o | output | 1 | Gated carrier drive bit |

## Verification
The bench instantiates the block with its default parameters: a 50 MHz clock, a 22 kHz target, a 6 µs start delay and a 35 µs stop target. This gives a 1136-cycle half period, a 300-cycle start countdown and a two-half-period drain. With these values the real microsecond windows become cycle counts that a directed run covers in a few thousand cycles. Both stop cases are reachable: an envelope fall during a high phase and one during a low phase. So is a cancel that lands after the first drain boundary, where a restart of the phase would show up as a wrong run length.

// File: rtl/tone_pkg.sv
package tone_pkg;

    typedef enum logic [1:0] {
        GATE_IDLE  = 2'd0,
        GATE_ARM   = 2'd1,
        GATE_RUN   = 2'd2,
        GATE_DRAIN = 2'd3
    } gate_state_e;

    // Rounded integer division used to derive cycle counts from rates and times.
    function automatic longint unsigned div_round(input longint unsigned num,
                                                  input longint unsigned den);
        return (num + den / 2) / den;
    endfunction

endpackage

// File: rtl/tone_sync.sv
module tone_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/tone_divider.sv
module tone_divider #(
    parameter int unsigned HALF_CYC = 1136,
    parameter int unsigned CNT_W    = 11
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic launch_i,
    input  logic advance_i,
    input  logic clear_i,
    output logic level_o,
    output logic boundary_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             lvl;
    } div_regs_t;

    div_regs_t div_d, div_q;

    always_comb begin
        div_d = div_q;
        if (launch_i) begin
            // a fresh carrier always begins with a full high phase
            div_d.cnt = '0;
            div_d.lvl = 1'b1;
        end else if (clear_i) begin
            div_d.cnt = '0;
            div_d.lvl = 1'b0;
        end else if (advance_i) begin
            if (div_q.cnt == LAST) begin
                div_d.cnt = '0;
                div_d.lvl = ~div_q.lvl;
            end else begin
                div_d.cnt = div_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    assign level_o    = div_q.lvl;
    assign boundary_o = advance_i && (div_q.cnt == LAST);

endmodule

// File: rtl/tone_gate.sv
module tone_gate import tone_pkg::*; #(
    parameter int unsigned START_CYC   = 300,
    parameter int unsigned STOP_HALVES = 2,
    parameter int unsigned START_W     = 9,
    parameter int unsigned HALVES_W    = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic env_i,
    input  logic en_i,
    input  logic boundary_i,
    output logic launch_o,
    output logic advance_o,
    output logic clear_o,
    output logic active_o
);

    typedef struct packed {
        gate_state_e           state;
        logic [START_W-1:0]    dly;
        logic [HALVES_W-1:0]   halves;
    } gate_regs_t;

    gate_regs_t gate_d, gate_q;
    logic       launch_d;

    always_comb begin
        gate_d   = gate_q;
        launch_d = 1'b0;
        if (!en_i) begin
            gate_d.state  = GATE_IDLE;
            gate_d.dly    = '0;
            gate_d.halves = '0;
        end else begin
            case (gate_q.state)
                GATE_IDLE: begin
                    if (env_i) begin
                        gate_d.state = GATE_ARM;
                        gate_d.dly   = START_W'(START_CYC - 1);
                    end
                end
                GATE_ARM: begin
                    if (!env_i) begin
                        gate_d.state = GATE_IDLE;
                    end else if (gate_q.dly == '0) begin
                        gate_d.state = GATE_RUN;
                        launch_d     = 1'b1;
                    end else begin
                        gate_d.dly = gate_q.dly - 1'b1;
                    end
                end
                GATE_RUN: begin
                    if (!env_i) begin
                        gate_d.state  = GATE_DRAIN;
                        gate_d.halves = HALVES_W'(STOP_HALVES);
                    end
                end
                GATE_DRAIN: begin
                    if (env_i) begin
                        // cancel: divider keeps its phase untouched
                        gate_d.state = GATE_RUN;
                    end else if (boundary_i) begin
                        if (gate_q.halves <= HALVES_W'(1)) begin
                            gate_d.state  = GATE_IDLE;
                            gate_d.halves = '0;
                        end else begin
                            gate_d.halves = gate_q.halves - 1'b1;
                        end
                    end
                end
                default: gate_d.state = GATE_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            gate_q.state  <= GATE_IDLE;
            gate_q.dly    <= '0;
            gate_q.halves <= '0;
        end else begin
            gate_q <= gate_d;
        end
    end

    assign active_o  = (gate_q.state == GATE_RUN) || (gate_q.state == GATE_DRAIN);
    assign advance_o = active_o;
    assign clear_o   = !active_o;
    assign launch_o  = launch_d;

endmodule

// File: rtl/tone_env_gen.sv
module tone_env_gen import tone_pkg::*; #(
    parameter int unsigned CLK_HZ      = 50_000_000,
    parameter int unsigned TONE_HZ     = 22_000,
    parameter int unsigned START_NS    = 6_000,
    parameter int unsigned STOP_NS     = 35_000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic env_i,
    input  logic en_i,
    output logic tone_o
);

    localparam int unsigned HALF_CYC  =
        int'(div_round(64'(CLK_HZ), 64'(2) * 64'(TONE_HZ)));
    localparam int unsigned START_CYC =
        int'(div_round(64'(CLK_HZ) * 64'(START_NS), 64'd1_000_000_000));
    localparam int unsigned STOP_CYC  =
        int'(div_round(64'(CLK_HZ) * 64'(STOP_NS), 64'd1_000_000_000));
    localparam int unsigned STOP_RAW  =
        int'(div_round(64'(STOP_CYC), 64'(HALF_CYC)));
    localparam int unsigned STOP_HALVES = (STOP_RAW == 0) ? 1 : STOP_RAW;
    localparam int unsigned CNT_W     = $clog2(HALF_CYC);
    localparam int unsigned START_W   = $clog2(START_CYC + 1);
    localparam int unsigned HALVES_W  = $clog2(STOP_HALVES + 1);

    logic env_sync;
    logic launch, advance, clear, active;
    logic level, boundary;

    tone_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i(env_i),
        .sync_o (env_sync)
    );

    tone_gate #(
        .START_CYC  (START_CYC),
        .STOP_HALVES(STOP_HALVES),
        .START_W    (START_W),
        .HALVES_W   (HALVES_W)
    ) u_gate (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .env_i     (env_sync),
        .en_i      (en_i),
        .boundary_i(boundary),
        .launch_o  (launch),
        .advance_o (advance),
        .clear_o   (clear),
        .active_o  (active)
    );

    tone_divider #(
        .HALF_CYC(HALF_CYC),
        .CNT_W   (CNT_W)
    ) u_div (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .launch_i  (launch),
        .advance_i (advance),
        .clear_i   (clear),
        .level_o   (level),
        .boundary_o(boundary)
    );

    assign tone_o = level && active && en_i;

endmodule

// File: rtl/tone_env_gen_chk.sv
module tone_env_gen_chk #(
    parameter int unsigned CLK_HZ      = 50_000_000,
    parameter int unsigned TONE_HZ     = 22_000,
    parameter int unsigned HALF_CYC    = 1136,
    parameter int unsigned BAND_PCT    = 9,
    parameter int unsigned MAX_STOP_NS = 60_000
) (
    input logic clk_i,
    input logic rst_ni,
    input logic env_i,
    input logic en_i,
    input logic tone_o
);

    localparam int unsigned HALF_LO = int'((64'(CLK_HZ) * 64'd100) /
        (64'd2 * 64'(TONE_HZ) * 64'(100 + BAND_PCT)));
    localparam int unsigned HALF_HI = int'((64'(CLK_HZ) * 64'd100) /
        (64'd2 * 64'(TONE_HZ) * 64'(100 - BAND_PCT))) + 1;
    localparam int unsigned MAX_STOP_CYC = int'((64'(CLK_HZ) * 64'(MAX_STOP_NS)) /
        64'd1_000_000_000);

    logic [31:0] hi_cnt_q;
    logic [31:0] env_lo_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hi_cnt_q <= '0;
            env_lo_q <= '0;
        end else begin
            hi_cnt_q <= tone_o ? hi_cnt_q + 1 : '0;
            if (env_i) begin
                env_lo_q <= '0;
            end else if (env_lo_q <= MAX_STOP_CYC) begin
                env_lo_q <= env_lo_q + 1;
            end
        end
    end

    // R9: output quiet while reset is held
    a_r9_reset_quiet: assert property (@(posedge clk_i) !rst_ni |-> !tone_o);

    // R8: a low enable masks the output in the same cycle
    a_r8_enable_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |-> !tone_o);

    // R1: each complete high phase stays inside the +/-9 % band
    a_r1_high_band: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(tone_o) && en_i && $past(en_i)) |->
            (hi_cnt_q >= HALF_LO) && (hi_cnt_q <= HALF_HI));

    // R6: no high phase is cut short when the carrier ends
    a_r6_full_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(tone_o) && en_i && $past(en_i)) |-> (hi_cnt_q == HALF_CYC));

    // R5: no carrier high later than the stop bound after the envelope falls
    a_r5_stop_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tone_o |-> (env_lo_q <= MAX_STOP_CYC));

endmodule

bind tone_env_gen tone_env_gen_chk #(
    .CLK_HZ  (CLK_HZ),
    .TONE_HZ (TONE_HZ),
    .HALF_CYC(HALF_CYC)
) u_chk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .env_i (env_i),
    .en_i  (en_i),
    .tone_o(tone_o)
);

// File: tb/tb_tone_env_gen.sv
module tb_tone_env_gen;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic env = 1'b0;
    logic en = 1'b1;
    logic tone;

    int n_chk = 0;
    int n_bad = 0;
    int h_ref = 1136;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    tone_env_gen dut (
        .clk_i (clk),
        .rst_ni(rst_n),
        .env_i (env),
        .en_i  (en),
        .tone_o(tone)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_level(input bit lvl, output int n);
        n = 0;
        while (tone !== lvl && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic run_len(input bit lvl, output int n);
        n = 0;
        while (tone === lvl && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic settle_idle();
        env = 1'b0;
        repeat (4000) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(tone === 1'b0, "R9 reset", tone, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(tone === 1'b0, "R9 after reset", tone, 0);
    endtask

    task automatic t_start_rate();
        int n, h, l;
        @(negedge clk);
        env = 1'b1;
        wait_level(1'b1, n);
        chk(n >= 250 && n <= 350, "R3 start delay", n, 300);
        for (int p = 0; p < 3; p++) begin
            run_len(1'b1, h);
            run_len(1'b0, l);
            chk(h + l >= 2084 && h + l <= 2500, "R1 period", h + l, 2272);
            chk(h == l && h * 100 >= 43 * (h + l) && h * 100 <= 57 * (h + l),
                "R2 duty", h, l);
            if (p == 0) h_ref = h;
        end
        settle_idle();
    endtask

    task automatic t_stop(input int fall_j);
        int n, hrun, last_hi, last_fall, rel;
        @(negedge clk);
        env = 1'b1;
        wait_level(1'b1, n);
        hrun = 1; last_hi = 0; last_fall = 0;
        for (int j = 1; j <= fall_j + 6000; j++) begin
            @(negedge clk);
            if (j == fall_j) env = 1'b0;
            if (tone === 1'b1) begin
                hrun++;
            end else if (hrun > 0) begin
                last_hi = hrun;
                last_fall = j;
                hrun = 0;
            end
        end
        rel = last_fall - fall_j;
        chk(rel <= 3000, "R5 last fall within 60us", rel, 3000);
        chk(rel + h_ref >= 750, "R5 carrier lasts 15us", rel + h_ref, 750);
        chk(tone === 1'b0 && hrun == 0, "R5 stays low", tone, 0);
        chk(last_hi == h_ref, "R6 last high full", last_hi, h_ref);
    endtask

    task automatic t_short();
        int highs = 0;
        @(negedge clk);
        env = 1'b1;
        repeat (100) @(negedge clk);
        env = 1'b0;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (tone === 1'b1) highs++;
        end
        chk(highs == 0, "R4 short pulse ignored", highs, 0);
    endtask

    task automatic t_cancel();
        int n, run, seen;
        bit prev;
        @(negedge clk);
        env = 1'b1;
        wait_level(1'b1, n);
        run = 1; seen = 0; prev = 1'b1;
        for (int j = 1; j < 9000 && seen < 6; j++) begin
            @(negedge clk);
            if (j == 1000) env = 1'b0;
            if (j == 1600) env = 1'b1;
            if (tone === prev) begin
                run++;
            end else begin
                chk(run == h_ref, "R7 cancel keeps phase", run, h_ref);
                seen++;
                run = 1;
                prev = tone;
            end
        end
        chk(seen == 6, "R7 carrier continued", seen, 6);
        settle_idle();
    endtask

    task automatic t_enable();
        int n, highs = 0;
        @(negedge clk);
        env = 1'b1;
        wait_level(1'b1, n);
        repeat (50) @(negedge clk);
        en = 1'b0;
        #1;
        chk(tone === 1'b0, "R8 immediate mask", tone, 0);
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (tone === 1'b1) highs++;
        end
        chk(highs == 0, "R8 stays masked", highs, 0);
        en = 1'b1;
        wait_level(1'b1, n);
        chk(n >= 250 && n <= 350, "R10 restart delay", n, 300);
        settle_idle();
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_start_rate();
        t_stop(400);
        settle_idle();
        t_stop(h_ref + 400);
        settle_idle();
        t_short();
        t_cancel();
        t_enable();
        summary();
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

endmodule